// File: doc/BRIEF.md
# Multi-Rail Power Sequencer

This block brings up a fixed chain of power rails in dependency order and reports a system-good flag once every rail is in regulation. Each rail has an enable output and a power-good (PG) input. Rail 0 (core) is enabled first, rail 1 (IO) next and rail 2 (memory) last. Each later rail is enabled only after the PG of the rail before it has been accepted and that rail's own stagger delay has run out. Every PG input passes through a two-flop synchronizer, a per-rail polarity inversion and a debounce filter before the control state machine uses it.

All waits are counted in ticks of an external strobe, normally one per millisecond. The waits are the per-rail stagger delays, the PG timeout, the post-power-up mute window, the gap between rails during power-down and the retry backoff. Two events count as a fault: a PG that does not arrive within the timeout, or a rail that loses its PG in the good state once the mute window has ended. On a fault the block switches the rails off from the highest down to rail 0. It then waits a backoff that doubles with each attempt and starts again. When the retry count reaches its limit, the block locks off until an explicit clear.

Top module: `rail_seq_ctrl`

## Requirements
- R1: After reset all rail enables are 0, `all_good` is 0, `seq_state` is 0 (idle), `retry_count` is 0 and `fail_valid` is 0.
- R2: With ticks every cycle, suppose rail i's raw PG becomes good D cycles after its enable rises. Then rail i+1's enable rises exactly D + DLY(i+1) + DEB_CYC + 3 cycles after rail i's enable. Enables are always a contiguous run from rail 0, and at most one enable rises per cycle.
- R3: If a rail's PG is not accepted within `pg_timeout` ticks of its enable, the block enters power-down (state code 4) with `fail_rail` set to that rail and `fail_valid` set to 1. A PG accepted in the same cycle the timeout expires counts as good, so with D the raw PG delay, a timeout of D+5 passes and D+4 fails.
- R4: A change on a PG input must hold for DEB_CYC consecutive cycles to be accepted. A glitch of DEB_CYC-1 cycles in the good state causes no fault.
- R5: When `pg_invert[i]` is 1, a low level on `pg_in[i]` means good, and sequencing proceeds with the same timing as a normal-polarity rail.
- R6: After the last rail's PG is accepted, the state is 3 (all good), `all_good` is 1 and every enable is 1.
- R7: During the first `mute_ticks` ticks of the good state, a loss of PG does not cause a fault. After the window, a loss starts power-down and reports the lowest failing rail.
- R8: Power-down clears enables one at a time from the highest enabled rail down to rail 0. The first rail drops one cycle after entry, and each later drop follows `down_gap`+1 tick cycles after the previous one.
- R9: After rail 0 drops in power-down with retry count k below the limit, the count becomes k+1. The state becomes 5 (backoff) for `backoff_base`<<k ticks, and rail 0 re-enables `backoff_base`<<k + DLY(0) + 2 cycles after it dropped.
- R10: When rail 0 drops in power-down with the retry count equal to `retry_limit`, the state becomes 6 (locked off) with all enables 0. Only `latch_clear` leaves that state, going to idle; `seq_start` has no effect there.
- R11: `retry_count`, `fail_rail` and `fail_valid` hold their values until a new sequence is started from idle, where they are cleared.
- R12: All timed waits advance only on cycles where `tick` is 1; with `tick` low, no enable rises after start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick | input | 1 | Time-base strobe; timers advance on cycles where it is 1 |
| seq_start | input | 1 | Starts a sequence when the block is idle |
| latch_clear | input | 1 | Leaves the locked-off state |
| pg_in | input | NUM_RAILS | Raw per-rail power-good inputs |
| pg_invert | input | NUM_RAILS | Per-rail PG polarity select (1 = active low) |
| up_delay | input | NUM_RAILS*TCNT_W | Per-rail stagger delay in ticks, rail 0 in the low bits |
| pg_timeout | input | TCNT_W | PG wait limit in ticks |
| mute_ticks | input | TCNT_W | Mute window length after reaching the good state |
| down_gap | input | TCNT_W | Ticks between rail drops during power-down |
| backoff_base | input | TCNT_W | Backoff for the first retry, doubled per retry |
| retry_limit | input | RETRY_W | Number of retries before locking off |
| rail_en | output | NUM_RAILS | Per-rail enable |
| all_good | output | 1 | All rails in regulation |
| seq_state | output | 3 | State code: 0 idle, 1 power-up, 2 wait PG, 3 good, 4 power-down, 5 backoff, 6 locked |
| retry_count | output | RETRY_W | Retries used in the current sequence |
| fail_rail | output | RID_W | Rail that caused the last fault |
| fail_valid | output | 1 | A fault has been recorded in this sequence |

## Verification
The sharpest coincidence is a rail's debounced PG landing in the same cycle that its timeout counter reaches zero. Both are serviced in the wait state, and the PG must win. The bench provokes this by setting the timeout to the rail model's PG delay plus five ticks, which makes the debounced PG and the expiry meet. The same run repeated with one tick less must end in a fault on that rail. A second overlap is a PG loss inside the mute window, where the timer that ends the window and the filter that reports the loss act together. It is judged by the block staying in the good state with no retry counted.

// File: rtl/rseq_pkg.sv
package rseq_pkg;
  typedef enum logic [2:0] {
    RS_IDLE    = 3'd0,
    RS_PWRUP   = 3'd1,
    RS_WAITPG  = 3'd2,
    RS_GOOD    = 3'd3,
    RS_PWRDN   = 3'd4,
    RS_BACKOFF = 3'd5,
    RS_LOCKED  = 3'd6
  } rseq_state_e;
endpackage

// File: rtl/rseq_pg_filter.sv
// One rail's power-good path: two-flop synchronizer, polarity select,
// then a filter that accepts a new level only after it has held steady.
module rseq_pg_filter #(
  parameter int DEB_CYC = 4,
  localparam int DW = $clog2(DEB_CYC + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pg_raw,
  input  logic pg_inv,
  output logic pg_ok
);
  logic sync1_q, sync2_q;
  logic lvl;
  logic ok_q, ok_d;
  logic [DW-1:0] run_q, run_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= 1'b0;
      sync2_q <= 1'b0;
    end else begin
      sync1_q <= pg_raw;
      sync2_q <= sync1_q;
    end
  end

  assign lvl = sync2_q ^ pg_inv;

  always_comb begin
    ok_d  = ok_q;
    run_d = run_q;
    if (lvl == ok_q) begin
      run_d = '0;
    end else if (run_q == DW'(DEB_CYC - 1)) begin
      ok_d  = lvl;
      run_d = '0;
    end else begin
      run_d = run_q + DW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ok_q  <= 1'b0;
      run_q <= '0;
    end else begin
      ok_q  <= ok_d;
      run_q <= run_d;
    end
  end

  assign pg_ok = ok_q;
endmodule

// File: rtl/rseq_timer.sv
// Shared tick-driven down counter; done while the count is zero.
module rseq_timer #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          done
);
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load) begin
      cnt_d = load_val;
    end else if (tick && (cnt_q != '0)) begin
      cnt_d = cnt_q - CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign done = (cnt_q == '0);
endmodule

// File: rtl/rseq_fsm.sv
// Sequencing control: ordered enables, PG wait with timeout, mute window,
// reverse power-down, doubling backoff and lock-off.
module rseq_fsm
  import rseq_pkg::*;
#(
  parameter int NR = 3,
  parameter int CW = 16,
  parameter int RW = 3,
  localparam int IW = (NR > 1) ? $clog2(NR) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           seq_start,
  input  logic           latch_clear,
  input  logic [NR-1:0]  pg_ok,
  input  logic [NR*CW-1:0] up_dly,
  input  logic [CW-1:0]  pg_timeout,
  input  logic [CW-1:0]  mute_ticks,
  input  logic [CW-1:0]  down_gap,
  input  logic [CW-1:0]  backoff_base,
  input  logic [RW-1:0]  retry_limit,
  input  logic           tmr_done,
  output logic           tmr_load,
  output logic [CW-1:0]  tmr_val,
  output logic [NR-1:0]  rail_en,
  output rseq_state_e    state,
  output logic [RW-1:0]  retry_cnt,
  output logic [IW-1:0]  fail_id,
  output logic           fail_vld
);
  rseq_state_e   st_q, st_d;
  logic [IW-1:0] idx_q, idx_d, idx_nx;
  logic [NR-1:0] en_q, en_d;
  logic [RW-1:0] rty_q, rty_d;
  logic [IW-1:0] fid_q, fid_d;
  logic          fv_q, fv_d;
  logic [IW-1:0] low_bad;
  logic [CW-1:0] dly_a [NR];

  for (genvar g = 0; g < NR; g++) begin : g_dly
    assign dly_a[g] = up_dly[g*CW +: CW];
  end

  assign idx_nx = idx_q + IW'(1);

  // lowest-numbered rail whose filtered PG is missing
  always_comb begin
    low_bad = '0;
    for (int i = NR - 1; i >= 0; i--) begin
      if (!pg_ok[i]) low_bad = IW'(i);
    end
  end

  always_comb begin
    st_d     = st_q;
    idx_d    = idx_q;
    en_d     = en_q;
    rty_d    = rty_q;
    fid_d    = fid_q;
    fv_d     = fv_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    unique case (st_q)
      RS_IDLE: begin
        if (seq_start) begin
          idx_d    = '0;
          rty_d    = '0;
          fid_d    = '0;
          fv_d     = 1'b0;
          tmr_load = 1'b1;
          tmr_val  = dly_a[0];
          st_d     = RS_PWRUP;
        end
      end
      RS_PWRUP: begin
        if (tmr_done) begin
          en_d[idx_q] = 1'b1;
          tmr_load    = 1'b1;
          tmr_val     = pg_timeout;
          st_d        = RS_WAITPG;
        end
      end
      RS_WAITPG: begin
        // an accepted PG takes priority over an expiring timeout
        if (pg_ok[idx_q]) begin
          tmr_load = 1'b1;
          if (idx_q == IW'(NR - 1)) begin
            tmr_val = mute_ticks;
            st_d    = RS_GOOD;
          end else begin
            idx_d   = idx_nx;
            tmr_val = dly_a[idx_nx];
            st_d    = RS_PWRUP;
          end
        end else if (tmr_done) begin
          fid_d    = idx_q;
          fv_d     = 1'b1;
          tmr_load = 1'b1;
          tmr_val  = '0;
          st_d     = RS_PWRDN;
        end
      end
      RS_GOOD: begin
        if (tmr_done && (pg_ok != {NR{1'b1}})) begin
          fid_d    = low_bad;
          fv_d     = 1'b1;
          tmr_load = 1'b1;
          tmr_val  = '0;
          st_d     = RS_PWRDN;
        end
      end
      RS_PWRDN: begin
        if (tmr_done) begin
          en_d[idx_q] = 1'b0;
          tmr_load    = 1'b1;
          if (idx_q == '0) begin
            if (rty_q == retry_limit) begin
              tmr_val = '0;
              st_d    = RS_LOCKED;
            end else begin
              rty_d   = rty_q + RW'(1);
              tmr_val = backoff_base << rty_q;
              st_d    = RS_BACKOFF;
            end
          end else begin
            idx_d   = idx_q - IW'(1);
            tmr_val = down_gap;
          end
        end
      end
      RS_BACKOFF: begin
        if (tmr_done) begin
          idx_d    = '0;
          tmr_load = 1'b1;
          tmr_val  = dly_a[0];
          st_d     = RS_PWRUP;
        end
      end
      RS_LOCKED: begin
        if (latch_clear) st_d = RS_IDLE;
      end
      default: st_d = RS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= RS_IDLE;
      idx_q <= '0;
      en_q  <= '0;
      rty_q <= '0;
      fid_q <= '0;
      fv_q  <= 1'b0;
    end else begin
      st_q  <= st_d;
      idx_q <= idx_d;
      en_q  <= en_d;
      rty_q <= rty_d;
      fid_q <= fid_d;
      fv_q  <= fv_d;
    end
  end

  assign rail_en   = en_q;
  assign state     = st_q;
  assign retry_cnt = rty_q;
  assign fail_id   = fid_q;
  assign fail_vld  = fv_q;
endmodule

// File: rtl/rail_seq_ctrl.sv
module rail_seq_ctrl
  import rseq_pkg::*;
#(
  parameter int NUM_RAILS = 3,
  parameter int TCNT_W    = 16,
  parameter int RETRY_W   = 3,
  parameter int DEB_CYC   = 4,
  localparam int RID_W    = (NUM_RAILS > 1) ? $clog2(NUM_RAILS) : 1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        tick,
  input  logic                        seq_start,
  input  logic                        latch_clear,
  input  logic [NUM_RAILS-1:0]        pg_in,
  input  logic [NUM_RAILS-1:0]        pg_invert,
  input  logic [NUM_RAILS*TCNT_W-1:0] up_delay,
  input  logic [TCNT_W-1:0]           pg_timeout,
  input  logic [TCNT_W-1:0]           mute_ticks,
  input  logic [TCNT_W-1:0]           down_gap,
  input  logic [TCNT_W-1:0]           backoff_base,
  input  logic [RETRY_W-1:0]          retry_limit,
  output logic [NUM_RAILS-1:0]        rail_en,
  output logic                        all_good,
  output logic [2:0]                  seq_state,
  output logic [RETRY_W-1:0]          retry_count,
  output logic [RID_W-1:0]            fail_rail,
  output logic                        fail_valid
);
  logic               rs1_q, rs2_q;
  logic               rst_int_n;
  logic [NUM_RAILS-1:0] pg_ok;
  logic               tmr_load, tmr_done;
  logic [TCNT_W-1:0]  tmr_val;
  rseq_state_e        state;

  // reset asserts at once, releases on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs1_q <= 1'b0;
      rs2_q <= 1'b0;
    end else begin
      rs1_q <= 1'b1;
      rs2_q <= rs1_q;
    end
  end
  assign rst_int_n = rs2_q;

  for (genvar r = 0; r < NUM_RAILS; r++) begin : g_pg
    rseq_pg_filter #(.DEB_CYC(DEB_CYC)) filt_i (
      .clk    (clk),
      .rst_n  (rst_int_n),
      .pg_raw (pg_in[r]),
      .pg_inv (pg_invert[r]),
      .pg_ok  (pg_ok[r])
    );
  end

  rseq_timer #(.CW(TCNT_W)) tmr_i (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .tick     (tick),
    .load     (tmr_load),
    .load_val (tmr_val),
    .done     (tmr_done)
  );

  rseq_fsm #(.NR(NUM_RAILS), .CW(TCNT_W), .RW(RETRY_W)) fsm_i (
    .clk          (clk),
    .rst_n        (rst_int_n),
    .seq_start    (seq_start),
    .latch_clear  (latch_clear),
    .pg_ok        (pg_ok),
    .up_dly       (up_delay),
    .pg_timeout   (pg_timeout),
    .mute_ticks   (mute_ticks),
    .down_gap     (down_gap),
    .backoff_base (backoff_base),
    .retry_limit  (retry_limit),
    .tmr_done     (tmr_done),
    .tmr_load     (tmr_load),
    .tmr_val      (tmr_val),
    .rail_en      (rail_en),
    .state        (state),
    .retry_cnt    (retry_count),
    .fail_id      (fail_rail),
    .fail_vld     (fail_valid)
  );

  assign seq_state = state;
  assign all_good  = (state == RS_GOOD);
endmodule

// File: rtl/rail_seq_ctrl_chk.sv
module rail_seq_ctrl_chk #(
  parameter int NR = 3,
  parameter int RW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          latch_clear,
  input logic [NR-1:0] rail_en,
  input logic          all_good,
  input logic [2:0]    seq_state,
  input logic [RW-1:0] retry_count,
  input logic          fail_valid
);
  // R2
  en_thermo_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((rail_en + NR'(1)) & rail_en) == '0);

  // R2
  one_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(rail_en & ~$past(rail_en)));

  // R8
  one_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0($past(rail_en) & ~rail_en));

  // R6
  good_all_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
    all_good |-> (rail_en == {NR{1'b1}}));

  // R10
  locked_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_state == 3'd6) |-> (rail_en == '0));

  // R10
  locked_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_state == 3'd6 && !latch_clear) |=> (seq_state == 3'd6));

  // R9
  backoff_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_state == 3'd5) |-> (rail_en == '0));

  // R3
  fail_enter_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fail_valid) |-> (seq_state == 3'd4));

  // R11
  retry_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(seq_state) != 3'd0) |-> (retry_count >= $past(retry_count)));
endmodule

bind rail_seq_ctrl rail_seq_ctrl_chk #(.NR(NUM_RAILS), .RW(RETRY_W)) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .latch_clear (latch_clear),
  .rail_en     (rail_en),
  .all_good    (all_good),
  .seq_state   (seq_state),
  .retry_count (retry_count),
  .fail_valid  (fail_valid)
);

// File: tb/rail_seq_ctrl_tb_top.sv
module rail_seq_ctrl_tb_top;
  localparam int NR  = 3;
  localparam int CW  = 16;
  localparam int RW  = 3;
  localparam int DEB = 4;
  localparam int DLY0 = 2, DLY1 = 10, DLY2 = 10;

  logic clk = 1'b0;
  logic rst_n, tick, seq_start, latch_clear;
  logic [NR-1:0] pg_in, pg_invert;
  logic [NR*CW-1:0] up_delay;
  logic [CW-1:0] pg_timeout, mute_ticks, down_gap, backoff_base;
  logic [RW-1:0] retry_limit;
  logic [NR-1:0] rail_en;
  logic all_good, fail_valid;
  logic [2:0] seq_state;
  logic [RW-1:0] retry_count;
  logic [1:0] fail_rail;

  always #4 clk = ~clk;

  rail_seq_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .tick(tick), .seq_start(seq_start),
    .latch_clear(latch_clear), .pg_in(pg_in), .pg_invert(pg_invert),
    .up_delay(up_delay), .pg_timeout(pg_timeout), .mute_ticks(mute_ticks),
    .down_gap(down_gap), .backoff_base(backoff_base), .retry_limit(retry_limit),
    .rail_en(rail_en), .all_good(all_good), .seq_state(seq_state),
    .retry_count(retry_count), .fail_rail(fail_rail), .fail_valid(fail_valid)
  );

  // rail models and event monitor
  int  pg_dly [NR];
  bit  never_pg [NR];
  bit  drop_pg [NR];
  int  mcnt [NR];
  int  cyc = 0;
  int  rise_t [NR];
  int  fall_t [NR];
  int  r0_hist [8];
  int  f0_hist [8];
  int  n_r0 = 0, n_f0 = 0;
  logic [NR-1:0] prev_en = '0;
  int  n_vec = 0, n_bad = 0;
  bit  done_flag = 0;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    for (int i = 0; i < NR; i++) begin
      if (rail_en[i] === 1'b1) begin
        if (mcnt[i] < 100000) mcnt[i] = mcnt[i] + 1;
      end else begin
        mcnt[i] = 0;
      end
      pg_in[i] = ((rail_en[i] === 1'b1) && (mcnt[i] >= pg_dly[i]) && !never_pg[i]
                  && !drop_pg[i]) ^ pg_invert[i];
      if (rail_en[i] === 1'b1 && prev_en[i] !== 1'b1) begin
        rise_t[i] = cyc;
        if (i == 0 && n_r0 < 8) begin r0_hist[n_r0] = cyc; n_r0 = n_r0 + 1; end
      end
      if (rail_en[i] !== 1'b1 && prev_en[i] === 1'b1) begin
        fall_t[i] = cyc;
        if (i == 0 && n_f0 < 8) begin f0_hist[n_f0] = cyc; n_f0 = n_f0 + 1; end
      end
    end
    prev_en = rail_en;
  end

  task automatic chk(input string req, input longint act, input longint exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    tick = 1'b1; seq_start = 1'b0; latch_clear = 1'b0;
    up_delay = {CW'(DLY2), CW'(DLY1), CW'(DLY0)};
    pg_timeout = 40; mute_ticks = 20; down_gap = 3; backoff_base = 8;
    retry_limit = 2;
    for (int i = 0; i < NR; i++) begin never_pg[i] = 0; drop_pg[i] = 0; end
    pg_dly[0] = 5; pg_dly[1] = 7; pg_dly[2] = 6;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;
  endtask

  task automatic pulse_start();
    @(posedge clk); #1 seq_start = 1'b1;
    @(posedge clk); #1 seq_start = 1'b0;
  endtask

  task automatic wait_st(input logic [2:0] code, input int maxc);
    int k;
    k = 0;
    @(negedge clk);
    while (seq_state !== code && k < maxc) begin
      @(negedge clk);
      k++;
    end
  endtask

  task automatic glitch(input int r, input int ncyc);
    @(posedge clk); #1 drop_pg[r] = 1;
    repeat (ncyc) @(posedge clk);
    #1 drop_pg[r] = 0;
  endtask

  initial begin
    pg_invert = '0;
    do_reset();
    @(negedge clk);
    // R1 reset state
    chk("R1 rail_en", rail_en, 0);
    chk("R1 all_good", all_good, 0);
    chk("R1 state", seq_state, 0);
    chk("R1 retry_count", retry_count, 0);
    chk("R1 fail_valid", fail_valid, 0);

    // R2 / R6 normal bring-up
    pulse_start();
    wait_st(3'd3, 400);
    chk("R6 all_good", all_good, 1);
    chk("R6 rail_en", rail_en, 7);
    chk("R2 gap rail0->rail1", rise_t[1] - rise_t[0], pg_dly[0] + DLY1 + DEB + 3);
    chk("R2 gap rail1->rail2", rise_t[2] - rise_t[1], pg_dly[1] + DLY2 + DEB + 3);

    // R4 short glitch after the mute window is ignored
    repeat (25) @(negedge clk);
    glitch(1, DEB - 1);
    repeat (20) @(negedge clk);
    chk("R4 short glitch all_good", all_good, 1);
    chk("R4 short glitch fail_valid", fail_valid, 0);

    // R7 loss after mute -> power-down, R8 order, R9 backoff
    glitch(1, 6);
    wait_st(3'd4, 50);
    chk("R7 state power-down", seq_state, 4);
    chk("R7 fail_rail", fail_rail, 1);
    chk("R3 fail_valid", fail_valid, 1);
    wait_st(3'd3, 600);
    chk("R9 retry_count", retry_count, 1);
    chk("R9 back to good", all_good, 1);
    chk("R8 drop 2->1 gap", fall_t[1] - fall_t[2], 4);
    chk("R8 drop 1->0 gap", fall_t[0] - fall_t[1], 4);
    chk("R9 first backoff", rise_t[0] - fall_t[0], 8 + DLY0 + 2);
    chk("R11 fail_rail held", fail_rail, 1);

    // R5 inverted polarity on rail 1
    pg_invert = 3'b010;
    do_reset();
    pulse_start();
    wait_st(3'd3, 400);
    chk("R5 all_good inverted", all_good, 1);
    chk("R5 gap rail0->rail1", rise_t[1] - rise_t[0], pg_dly[0] + DLY1 + DEB + 3);
    chk("R5 gap rail1->rail2", rise_t[2] - rise_t[1], pg_dly[1] + DLY2 + DEB + 3);
    pg_invert = '0;

    // R7 loss inside the mute window is ignored
    do_reset();
    pulse_start();
    wait_st(3'd3, 400);
    glitch(0, 8);
    repeat (40) @(negedge clk);
    chk("R7 mute all_good", all_good, 1);
    chk("R7 mute retry_count", retry_count, 0);
    chk("R7 mute fail_valid", fail_valid, 0);

    // R3 timeout boundary: D+4 fails, lock with no retries
    do_reset();
    pg_timeout = CW'(pg_dly[1] + 4);
    retry_limit = 0;
    pulse_start();
    wait_st(3'd6, 400);
    chk("R3 timeout locked", seq_state, 6);
    chk("R3 timeout fail_rail", fail_rail, 1);
    chk("R3 timeout to drop", fall_t[1] - rise_t[1], pg_dly[1] + 4 + 2);
    chk("R10 locked rail_en", rail_en, 0);
    pulse_start();
    repeat (10) @(negedge clk);
    chk("R10 start ignored when locked", seq_state, 6);
    @(posedge clk); #1 latch_clear = 1'b1;
    @(posedge clk); #1 latch_clear = 1'b0;
    @(negedge clk);
    chk("R10 clear to idle", seq_state, 0);

    // R3 timeout boundary: D+5 coincides with PG and passes
    do_reset();
    pg_timeout = CW'(pg_dly[1] + 5);
    pulse_start();
    wait_st(3'd3, 400);
    chk("R3 coincident PG wins", all_good, 1);
    chk("R3 coincident no fault", fail_valid, 0);

    // R9 / R10 / R11 retries with doubling backoff then lock-off
    do_reset();
    never_pg[2] = 1;
    @(posedge clk); #1 n_r0 = 0; n_f0 = 0;
    pulse_start();
    wait_st(3'd6, 2000);
    chk("R10 locked after cap", seq_state, 6);
    chk("R10 retry_count at cap", retry_count, 2);
    chk("R10 fail_rail", fail_rail, 2);
    chk("R9 attempts", n_r0, 3);
    chk("R9 backoff k=0", r0_hist[1] - f0_hist[0], 8 + DLY0 + 2);
    chk("R9 backoff k=1", r0_hist[2] - f0_hist[1], 16 + DLY0 + 2);
    repeat (30) @(negedge clk);
    chk("R11 retry held while locked", retry_count, 2);
    chk("R11 fail_valid held", fail_valid, 1);
    @(posedge clk); #1 latch_clear = 1'b1;
    @(posedge clk); #1 latch_clear = 1'b0;
    @(negedge clk);
    chk("R11 retry held in idle", retry_count, 2);
    never_pg[2] = 0;
    pulse_start();
    @(negedge clk);
    chk("R11 retry cleared on start", retry_count, 0);
    chk("R11 fail_valid cleared on start", fail_valid, 0);

    // R12 timers stall without tick
    do_reset();
    tick = 1'b0;
    pulse_start();
    repeat (50) @(negedge clk);
    chk("R12 no enable without tick", rail_en, 0);
    chk("R12 still in power-up", seq_state, 1);
    @(posedge clk); #1 tick = 1'b1;
    repeat (10) @(negedge clk);
    chk("R12 enable after tick", rail_en[0], 1);

    done_flag = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done_flag) begin
      n_vec++;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule